// File: doc/BRIEF.md
# Power-Management Event and Interrupt Controller

This block is the event front end of an ACPI-style power-management function. It keeps a 16-bit event status register and a 16-bit event enable register. One-cycle pulses on `evt_pulse` set status bits. Software clears a status bit by writing a one to its position through a relocatable 64-byte I/O window. The level-sensitive `sci` interrupt is high while any status bit is both set and enabled, but only in the timer, global-lock, power-button and RTC positions. The block also reports whether the timer-overflow wakeup should be armed. The free-running timer itself lives outside the block.

The window base and the window enable come from a small byte-wide configuration write port. The same port holds a secondary SMBus base, which is published 16-byte aligned for a neighbouring controller.

I/O requests use valid/ready. `io_req_ready` is tied high, so the block never applies back-pressure and every request is taken in the cycle its valid is high. A read returns a one-cycle `io_rsp_valid` pulse one clock later. The response has no ready input, so the requester must always accept it. Writes produce no response.

Top module: `pm_evt_ctrl`

## Requirements
- R1: After reset, status and enable are all zero, `sci` and `tmr_armed` are low, the window is disabled, `win_base` is 0 and `smb_base` equals parameter `SMB_RST` with its low 4 bits cleared.
- R2: A high `evt_pulse[i]` at a clock edge sets status bit i at that edge. The bit then stays set until it is cleared. Timer is bit 0, global lock is bit 5, power button is bit 8 and RTC is bit 10.
- R3: A window write to status byte k (offset 0 = bits 7:0, offset 1 = bits 15:8) clears each bit written as 1 and leaves bits written as 0 unchanged. If an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A window write to enable byte k (offset 2 = bits 7:0, offset 3 = bits 15:8) stores the written byte directly.
- R5: `sci` is high exactly when status AND enable is non-zero in bit 0, 5, 8 or 10 (mask 0x0521). It follows the registers in the same cycle they change, and no other bit affects it.
- R6: `tmr_armed` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R7: A config write to address 0x40 or 0x41 sets the low or high byte of the raw window base. `win_base` is the raw base ANDed with 0xFFC0.
- R8: Bit 0 of a config write to address 0x80 sets `win_en`. Only while it is high does the window decode addresses `win_base` to `win_base+63`.
- R9: A read that hits the window returns `io_rsp_hit`=1. Offsets 0 to 3 return the status and enable bytes described in R3 and R4. Any other offset in the window returns 0x00.
- R10: A read outside the window, or while the window is disabled, returns `io_rsp_hit`=0 and data 0xFF. A write in either case changes nothing.
- R11: A config write to address 0x90 stores the byte with bit 0 forced to 1, and a write to 0x91 stores the high byte. `smb_base` is that 16-bit value with its low 4 bits cleared.
- R12: `io_req_ready` is always 1. A read raises `io_rsp_valid` for exactly the next cycle. Its data reflects the register values before any update made in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 16 | One-cycle event pulses, one per status bit |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration byte address |
| cfg_wr_data | input | 8 | Configuration write data |
| io_req_valid | input | 1 | I/O request valid |
| io_req_ready | output | 1 | I/O request ready (always 1) |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | 16 | I/O byte address |
| io_req_wdata | input | 8 | I/O write data |
| io_rsp_valid | output | 1 | Read response valid, one cycle after the request |
| io_rsp_hit | output | 1 | Read was claimed by the window |
| io_rsp_data | output | 8 | Read data |
| win_en | output | 1 | Window decode enabled |
| win_base | output | 16 | 64-byte aligned window base |
| smb_base | output | 16 | 16-byte aligned secondary SMBus base |
| sci | output | 1 | Level-sensitive interrupt |
| tmr_armed | output | 1 | Timer-overflow wakeup armed |

## Verification
The bound checker checks these properties on every cycle:
- the reset state of `sci`, `tmr_armed` and `win_en`;
- the one-cycle read response and the 0xFF miss data;
- that a disabled window never claims a read;
- that a timer event always disarms the timer;
- that `sci` cannot rise without a masked-in event or an I/O access;
- that the configuration bytes reach the published bases.

The exact mapping of `sci` to each of the 16 status positions, write-one-to-clear with partial masks, set-beats-clear collisions, window edges across several bases, and SMBus bit forcing can only be shown by the bench's sweeps against its own model of the two registers.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int PM_REG_W = 16;
  localparam int PM_ADDR_W = 16;
  localparam int BIT_TMR    = 0;
  localparam int BIT_GBL    = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_RTC    = 10;
  localparam logic [PM_REG_W-1:0] SCI_SRC_MASK =
    PM_REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));
  localparam logic [7:0] CFG_WBASE_LO = 8'h40;
  localparam logic [7:0] CFG_WBASE_HI = 8'h41;
  localparam logic [7:0] CFG_WCTRL    = 8'h80;
  localparam logic [7:0] CFG_SMB_LO   = 8'h90;
  localparam logic [7:0] CFG_SMB_HI   = 8'h91;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_evt_pkg::*;
#(
  parameter int WIN_AW = 6,
  parameter int SMB_AW = 4,
  parameter logic [PM_ADDR_W-1:0] SMB_RST = 16'hEEE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic                 win_en,
  output logic [PM_ADDR_W-1:0] win_base,
  output logic [PM_ADDR_W-1:0] smb_base
);
  localparam logic [PM_ADDR_W-1:0] WIN_MASK = ~PM_ADDR_W'((32'd1 << WIN_AW) - 1);
  localparam logic [PM_ADDR_W-1:0] SMB_MASK = ~PM_ADDR_W'((32'd1 << SMB_AW) - 1);

  logic [PM_ADDR_W-1:0] wb_q;
  logic [PM_ADDR_W-1:0] smb_q;
  logic                 wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q  <= '0;
      wen_q <= 1'b0;
      smb_q <= SMB_RST | PM_ADDR_W'(1);
    end else if (wr_en) begin
      case (wr_addr)
        CFG_WBASE_LO: wb_q[7:0]   <= wr_data;
        CFG_WBASE_HI: wb_q[15:8]  <= wr_data;
        CFG_WCTRL:    wen_q       <= wr_data[0];
        CFG_SMB_LO:   smb_q[7:0]  <= wr_data | 8'h01;
        CFG_SMB_HI:   smb_q[15:8] <= wr_data;
        default: ;
      endcase
    end
  end

  assign win_en   = wen_q;
  assign win_base = wb_q & WIN_MASK;
  assign smb_base = smb_q & SMB_MASK;
endmodule

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_evt_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input  logic [PM_ADDR_W-1:0] addr,
  input  logic [PM_ADDR_W-1:0] win_base,
  input  logic                 win_en,
  output logic                 hit,
  output logic [WIN_AW-1:0]    ofs
);
  assign hit = win_en && (addr[PM_ADDR_W-1:WIN_AW] == win_base[PM_ADDR_W-1:WIN_AW]);
  assign ofs = addr[WIN_AW-1:0];
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PM_REG_W-1:0] evt_pulse,
  input  logic                wr_en,
  input  logic [WIN_AW-1:0]   wr_ofs,
  input  logic [7:0]          wr_data,
  input  logic [WIN_AW-1:0]   rd_ofs,
  output logic [7:0]          rd_data,
  output logic                sci,
  output logic                tmr_armed
);
  localparam int NB = PM_REG_W / 8;
  localparam int STS_OFS = 0;
  localparam int EN_OFS = NB;

  logic [PM_REG_W-1:0] sts_q;
  logic [PM_REG_W-1:0] en_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic       sts_sel;
    logic       en_sel;
    logic [7:0] sts_lane;
    logic [7:0] en_lane;
    assign sts_sel = wr_en && (wr_ofs == WIN_AW'(STS_OFS + b));
    assign en_sel  = wr_en && (wr_ofs == WIN_AW'(EN_OFS + b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_lane <= '0;
        en_lane  <= '0;
      end else begin
        sts_lane <= (sts_lane & ~(sts_sel ? wr_data : 8'h00)) | evt_pulse[b*8 +: 8];
        if (en_sel) en_lane <= wr_data;
      end
    end
    assign sts_q[b*8 +: 8] = sts_lane;
    assign en_q[b*8 +: 8]  = en_lane;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < NB; b++) begin
      if (rd_ofs == WIN_AW'(STS_OFS + b)) rd_data = sts_q[b*8 +: 8];
      if (rd_ofs == WIN_AW'(EN_OFS + b))  rd_data = en_q[b*8 +: 8];
    end
  end

  assign sci       = |(sts_q & en_q & SCI_SRC_MASK);
  assign tmr_armed = en_q[BIT_TMR] & ~sts_q[BIT_TMR];
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int WIN_AW = 6,
  parameter int SMB_AW = 4,
  parameter logic [15:0] SMB_RST = 16'hEEE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] evt_pulse,
  input  logic        cfg_wr_en,
  input  logic [7:0]  cfg_wr_addr,
  input  logic [7:0]  cfg_wr_data,
  input  logic        io_req_valid,
  output logic        io_req_ready,
  input  logic        io_req_write,
  input  logic [15:0] io_req_addr,
  input  logic [7:0]  io_req_wdata,
  output logic        io_rsp_valid,
  output logic        io_rsp_hit,
  output logic [7:0]  io_rsp_data,
  output logic        win_en,
  output logic [15:0] win_base,
  output logic [15:0] smb_base,
  output logic        sci,
  output logic        tmr_armed
);
  logic              hit;
  logic [WIN_AW-1:0] ofs;
  logic [7:0]        rd_byte;
  logic              rd_fire;
  logic              wr_fire;

  assign io_req_ready = 1'b1;
  assign rd_fire = io_req_valid && io_req_ready && !io_req_write;
  assign wr_fire = io_req_valid && io_req_ready && io_req_write && hit;

  pm_cfg_regs #(.WIN_AW(WIN_AW), .SMB_AW(SMB_AW), .SMB_RST(SMB_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .win_en(win_en), .win_base(win_base), .smb_base(smb_base)
  );

  pm_io_decode #(.WIN_AW(WIN_AW)) u_dec (
    .addr(io_req_addr), .win_base(win_base), .win_en(win_en), .hit(hit), .ofs(ofs)
  );

  pm_evt_regs #(.WIN_AW(WIN_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_fire), .wr_ofs(ofs),
    .wr_data(io_req_wdata), .rd_ofs(ofs), .rd_data(rd_byte), .sci(sci),
    .tmr_armed(tmr_armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rsp_valid <= 1'b0;
      io_rsp_hit   <= 1'b0;
      io_rsp_data  <= 8'hFF;
    end else begin
      io_rsp_valid <= rd_fire;
      io_rsp_hit   <= rd_fire && hit;
      io_rsp_data  <= (rd_fire && hit) ? rd_byte : 8'hFF;
    end
  end
endmodule

// File: rtl/pm_evt_ctrl_chk.sv
module pm_evt_ctrl_chk
  import pm_evt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] evt_pulse,
  input logic        cfg_wr_en,
  input logic [7:0]  cfg_wr_addr,
  input logic [7:0]  cfg_wr_data,
  input logic        io_req_valid,
  input logic        io_req_write,
  input logic        io_rsp_valid,
  input logic        io_rsp_hit,
  input logic [7:0]  io_rsp_data,
  input logic        win_en,
  input logic [15:0] win_base,
  input logic [15:0] smb_base,
  input logic        sci,
  input logic        tmr_armed
);
  // R1
  rst_state_chk: assert property (@(posedge clk) !rst_n |=> (!win_en && !sci && !tmr_armed));
  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && !io_req_write) |=> io_rsp_valid);
  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req_valid && !io_req_write) |=> !io_rsp_valid);
  // R10
  miss_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && !io_rsp_hit) |-> (io_rsp_data == 8'hFF));
  // R8
  dis_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && !io_req_write && !win_en) |=> !io_rsp_hit);
  // R6
  tmr_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[BIT_TMR] |=> !tmr_armed);
  // R5
  sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci && ((evt_pulse & SCI_SRC_MASK) == '0) && !io_req_valid) |=> !sci);
  // R7
  wbase_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_addr == CFG_WBASE_HI) |=> (win_base[15:8] == $past(cfg_wr_data)));
  // R11
  smb_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_addr == CFG_SMB_LO) |=> (smb_base[7:4] == $past(cfg_wr_data[7:4])));
endmodule

bind pm_evt_ctrl pm_evt_ctrl_chk u_chk (.*);

// File: tb/pm_evt_ctrl_bench.sv
module pm_evt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_pulse = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic        io_req_valid = 1'b0;
  logic        io_req_ready;
  logic        io_req_write = 1'b0;
  logic [15:0] io_req_addr = '0;
  logic [7:0]  io_req_wdata = '0;
  logic        io_rsp_valid, io_rsp_hit;
  logic [7:0]  io_rsp_data;
  logic        win_en, sci, tmr_armed;
  logic [15:0] win_base, smb_base;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_sts = '0;
  logic [15:0] exp_en = '0;
  logic [15:0] wb = 16'h1240;
  localparam logic [15:0] MASK = 16'h0521;

  always #10 clk = ~clk;

  pm_evt_ctrl u_pm_evt_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    io_req_valid = 1'b1; io_req_write = 1'b1; io_req_addr = a; io_req_wdata = d;
    @(posedge clk); @(negedge clk);
    io_req_valid = 1'b0; io_req_write = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d, output logic h);
    io_req_valid = 1'b1; io_req_write = 1'b0; io_req_addr = a;
    @(posedge clk); @(negedge clk);
    io_req_valid = 1'b0;
    chk("R12 rsp_valid", io_rsp_valid, 1);
    d = io_rsp_data; h = io_rsp_hit;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt_pulse = v;
    @(posedge clk); @(negedge clk);
    evt_pulse = '0;
  endtask

  function automatic logic exp_sci();
    return |(exp_sts & exp_en & MASK);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sci", sci, 0);
    chk("R1 tmr_armed", tmr_armed, 0);
    chk("R1 win_en", win_en, 0);
    chk("R1 win_base", win_base, 0);
    chk("R1 smb_base", smb_base, 16'hEEE0);
    // R10 disabled window at reset
    io_rd(16'h0000, d, h);
    chk("R10 reset miss hit", h, 0);
    chk("R10 reset miss data", d, 8'hFF);
    @(negedge clk);
    chk("R12 rsp single cycle", io_rsp_valid, 0);

    cfg_wr(8'h40, 8'h7F);
    cfg_wr(8'h41, 8'h12);
    cfg_wr(8'h80, 8'h01);
    chk("R7 win_base", win_base, 16'h1240);
    chk("R8 win_en", win_en, 1);

    // R4 enable store and readback
    io_wr(wb + 2, 8'hFF); io_wr(wb + 3, 8'hFF); exp_en = 16'hFFFF;
    io_rd(wb + 2, d, h); chk("R4 en lo", d, 8'hFF); chk("R9 hit", h, 1);
    io_rd(wb + 3, d, h); chk("R4 en hi", d, 8'hFF);
    chk("R1 sts empty after reset", exp_sts, 0);
    chk("R6 armed when enabled", tmr_armed, 1);

    // R2/R3/R5/R6 sweep over all 16 status positions
    for (int i = 0; i < 16; i++) begin
      pulse(16'h1 << i); exp_sts = 16'h1 << i;
      chk($sformatf("R5 sci bit %0d", i), sci, exp_sci());
      chk($sformatf("R6 armed bit %0d", i), tmr_armed, (i != 0));
      io_rd(wb + 0, d, h); chk($sformatf("R2 sts lo bit %0d", i), d, exp_sts[7:0]);
      io_rd(wb + 1, d, h); chk($sformatf("R2 sts hi bit %0d", i), d, exp_sts[15:8]);
      io_wr(wb + (i / 8), 8'h1 << (i % 8)); exp_sts = '0;
      chk($sformatf("R3 sci clear bit %0d", i), sci, 0);
      io_rd(wb + (i / 8), d, h); chk($sformatf("R3 cleared bit %0d", i), d, 0);
    end

    // R5 enable masking, sci rises in the cycle after the enable write
    io_wr(wb + 3, 8'hFB); exp_en = 16'hFBFF;
    pulse(16'h0400); exp_sts = 16'h0400;
    chk("R5 masked rtc", sci, 0);
    io_wr(wb + 3, 8'h04); exp_en = 16'h04FF;
    chk("R5 enabled rtc", sci, 1);
    io_wr(wb + 1, 8'h04); exp_sts = '0;
    chk("R5 rtc cleared", sci, 0);

    // R3 partial clear
    pulse(16'h0120); exp_sts = 16'h0120;
    io_wr(wb + 0, 8'h00);
    io_rd(wb + 0, d, h); chk("R3 zero write keeps", d, 8'h20);
    io_wr(wb + 1, 8'h01); exp_sts = 16'h0020;
    io_rd(wb + 1, d, h); chk("R3 hi cleared", d, 8'h00);
    io_rd(wb + 0, d, h); chk("R3 lo kept", d, 8'h20);
    io_wr(wb + 0, 8'hFF); exp_sts = '0;

    // R3 event and clear in the same cycle: set wins
    pulse(16'h0100);
    evt_pulse = 16'h0100;
    io_wr(wb + 1, 8'h01);
    evt_pulse = '0;
    io_rd(wb + 1, d, h); chk("R3 set beats clear", d, 8'h01);
    // R12 read sees pre-update value
    evt_pulse = 16'h0001;
    io_rd(wb + 0, d, h);
    evt_pulse = '0;
    chk("R12 pre-update read", d, 8'h00);
    io_rd(wb + 0, d, h); chk("R2 post-update read", d, 8'h01);
    io_wr(wb + 0, 8'hFF); io_wr(wb + 1, 8'hFF);

    // R6 timer arming
    io_wr(wb + 2, 8'h00); io_wr(wb + 3, 8'h00);
    chk("R6 disabled", tmr_armed, 0);
    io_wr(wb + 2, 8'h01);
    chk("R6 enabled", tmr_armed, 1);

    // R9 other offsets
    io_rd(wb + 4, d, h); chk("R9 reserved hit", h, 1); chk("R9 reserved data", d, 0);

    // R7/R8/R9/R10 window sweep
    for (int k = 0; k < 6; k++) begin
      logic [15:0] raw;
      raw = {8'(k * 37 + 3), 8'(k * 91 + 5)};
      cfg_wr(8'h40, raw[7:0]); cfg_wr(8'h41, raw[15:8]);
      wb = raw & 16'hFFC0;
      chk($sformatf("R7 base %0d", k), win_base, wb);
      io_rd(wb - 1, d, h);  chk($sformatf("R10 below %0d", k), {h, d}, 9'h0FF);
      io_rd(wb, d, h);      chk($sformatf("R9 first %0d", k), h, 1);
      io_rd(wb + 63, d, h); chk($sformatf("R9 last %0d", k), {h, d}, 9'h100);
      io_rd(wb + 64, d, h); chk($sformatf("R10 above %0d", k), {h, d}, 9'h0FF);
    end

    // R8/R10 disabled window ignores writes
    cfg_wr(8'h80, 8'hFE);
    chk("R8 disabled", win_en, 0);
    io_rd(wb + 2, d, h); chk("R10 disabled read", {h, d}, 9'h0FF);
    io_wr(wb + 2, 8'h00);
    cfg_wr(8'h80, 8'h01);
    io_rd(wb + 2, d, h); chk("R10 write ignored", d, 8'h01);

    // R11 SMBus base sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] lo, hi;
      lo = 8'(k * 17); hi = 8'(255 - k);
      cfg_wr(8'h90, lo); cfg_wr(8'h91, hi);
      chk($sformatf("R11 smb %0d", k), smb_base, {hi, lo[7:4], 4'h0});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule